// File: doc/BRIEF.md
# DDR Clock Generator with PLL Bypass

This block generates the clock for a DDR memory clock domain. It takes a reference clock from one of two sources and either passes that reference straight through (bypass) or sends it through a behavioural PLL, which multiplies the reference rate, and then a post-divider. Every clock is modelled as a single-cycle clock-enable pulse on one fast system clock, so the block stays fully synchronous and synthesizable. A counter-based lock timer stands in for the analog loop.

Software drives the block through a small register port with write enable, address, write data and combinational read data. After reset the PLL is powered down and the memory clock runs in bypass. To move onto the PLL, software clears the power-down bit, polls the read-only lock flag, and then sets the enable bit. A second divider on the reference path gives a bypass clock that runs at all times. Changes between the bypass and PLL sources are held back until a cycle where neither candidate pulse is active, so no pulse is ever cut short or duplicated.

Top module: `pllc_ddr_clkgen`

## Requirements
- R1: After reset, control reads back power-down=1, enable=0 and lock=0. The multiplier field reads MULT_RST (4), the post-divider field reads POST_RST (1), the bypass-divider field reads BYP_RST (0), and the memory clock is in bypass.
- R2: While the PLL path is not selected, `mem_clk_en` equals the selected reference tick in the same cycle.
- R3: `src_ext`=1 selects `ext_tick` as the reference and `src_ext`=0 selects `osc_tick`. The choice affects the bypass path, the PLL and both dividers.
- R4: Once power-down is cleared, the lock flag (control bit 2) sets on the cycle after the LOCK_TICKS-th reference tick. It clears, and the count restarts, whenever power-down is set or the multiplier register is written.
- R5: A control write that sets enable (bit 1) while lock is 0 is ignored: enable reads back 0 and the output stays in bypass. Enable clears itself one cycle after lock drops.
- R6: While powered up, the PLL emits M pulses per reference tick on average, where M is the multiplier register value and a value of 0 counts as 1. No PLL pulse occurs while the PLL is powered down.
- R7: With the PLL path selected, `mem_clk_en` pulses on every (D+1)-th PLL pulse, where D is the post-divider register value.
- R8: `byp_clk_en` pulses on every (B+1)-th reference tick, where B is the bypass-divider register value, in every mode.
- R9: The source select (`pll_selected`) follows the enable bit, but it changes only after a cycle in which both the reference tick and the post-divided PLL pulse are low.
- R10: Register map: address 0 is control (bit 0 power-down, bit 1 enable, bit 2 lock, read-only), address 1 is the multiplier, address 2 is the post-divider and address 3 is the bypass divider. Read data is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Oscillator reference clock-enable pulse |
| ext_tick | input | 1 | External reference clock-enable pulse |
| src_ext | input | 1 | Reference source select, 1 = external |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| mem_clk_en | output | 1 | Memory clock enable pulse |
| byp_clk_en | output | 1 | Divided bypass clock enable pulse |
| pll_locked | output | 1 | PLL lock flag |
| pll_selected | output | 1 | Memory clock currently taken from the PLL path |

## Verification
The two reference sources tick at different periods (every 5 and every 7 cycles), so a wrong source select shows up as a pulse-rate error. The PLL path is run with multipliers of 4, 0 and 3 and post-dividers of 1, 2 and 0. Each combination gives a different pulse count over a fixed window, which separates multiplier faults from divider faults and from the bypass rate. An enable write issued before lock, a multiplier rewrite and a power-down issued while on the PLL path check that the select stays on, or falls back to, the reference. A per-cycle reference model also catches selects that switch while a pulse is active.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_MULT = 2'd1,
      REG_POST = 2'd2,
      REG_BYP  = 2'd3
   } reg_sel_e;

   localparam int CTL_PWRDN = 0;
   localparam int CTL_EN    = 1;
   localparam int CTL_LOCK  = 2;
endpackage

// File: rtl/pllc_regs.sv
module pllc_regs
   import pllc_pkg::*;
#(
   parameter int DW       = 8,
   parameter int MULT_W   = 6,
   parameter int DIV_W    = 4,
   parameter int MULT_RST = 4,
   parameter int POST_RST = 1,
   parameter int BYP_RST  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              locked_i,
   output logic [DW-1:0]     rdata_o,
   output logic              pwrdn_o,
   output logic              en_o,
   output logic              mult_wr_o,
   output logic [MULT_W-1:0] mult_eff_o,
   output logic [DIV_W-1:0]  post_o,
   output logic [DIV_W-1:0]  byp_o
);
   logic              pwrdn_q, en_q;
   logic [MULT_W-1:0] mult_q;
   logic [DIV_W-1:0]  post_q, byp_q;
   logic              wr_ctrl, wr_post, wr_byp;
   logic              unused_wbits;

   assign unused_wbits = ^wdata_i;
   assign wr_ctrl   = we_i && (addr_i == REG_CTRL);
   assign mult_wr_o = we_i && (addr_i == REG_MULT);
   assign wr_post   = we_i && (addr_i == REG_POST);
   assign wr_byp    = we_i && (addr_i == REG_BYP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwrdn_q <= 1'b1;
         en_q    <= 1'b0;
         mult_q  <= MULT_W'(MULT_RST);
         post_q  <= DIV_W'(POST_RST);
         byp_q   <= DIV_W'(BYP_RST);
      end else begin
         if (wr_ctrl)   pwrdn_q <= wdata_i[CTL_PWRDN];
         if (mult_wr_o) mult_q  <= wdata_i[MULT_W-1:0];
         if (wr_post)   post_q  <= wdata_i[DIV_W-1:0];
         if (wr_byp)    byp_q   <= wdata_i[DIV_W-1:0];
         en_q <= locked_i && (wr_ctrl ? wdata_i[CTL_EN] : en_q);
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         REG_CTRL: begin
            rdata_o[CTL_PWRDN] = pwrdn_q;
            rdata_o[CTL_EN]    = en_q;
            rdata_o[CTL_LOCK]  = locked_i;
         end
         REG_MULT: rdata_o[MULT_W-1:0] = mult_q;
         REG_POST: rdata_o[DIV_W-1:0]  = post_q;
         default:  rdata_o[DIV_W-1:0]  = byp_q;
      endcase
   end

   assign pwrdn_o    = pwrdn_q;
   assign en_o       = en_q;
   assign mult_eff_o = (mult_q == '0) ? MULT_W'(1) : mult_q;
   assign post_o     = post_q;
   assign byp_o      = byp_q;

   assert_en_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(locked_i));
   assert_en_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !locked_i) |=> !en_q);
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
   parameter int LOCK_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwrdn_i,
   input  logic restart_i,
   input  logic ref_i,
   output logic locked_o
);
   localparam int CNT_W = (LOCK_TICKS > 2) ? $clog2(LOCK_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         locked_q <= 1'b0;
      end else if (pwrdn_i || restart_i) begin
         cnt_q    <= '0;
         locked_q <= 1'b0;
      end else if (ref_i && !locked_q) begin
         if (cnt_q == LAST) locked_q <= 1'b1;
         else               cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign locked_o = locked_q;

   assert_lock_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(!pwrdn_i && !restart_i && ref_i));
   assert_lock_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrdn_i || restart_i) |=> !locked_q);
endmodule

// File: rtl/pllc_vco_model.sv
module pllc_vco_model #(
   parameter int MULT_W   = 6,
   parameter int CREDIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn_i,
   input  logic              ref_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic              vco_o
);
   logic [CREDIT_W-1:0] credit_q;
   logic [CREDIT_W:0]   sum;
   logic                vco_q;
   logic                have;

   assign have = (credit_q != '0);

   always_comb begin
      sum = {1'b0, credit_q};
      if (ref_i) sum = sum + (CREDIT_W+1)'(mult_i);
      if (have)  sum = sum - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         credit_q <= '0;
         vco_q    <= 1'b0;
      end else if (pwrdn_i) begin
         credit_q <= '0;
         vco_q    <= 1'b0;
      end else begin
         vco_q    <= have;
         credit_q <= sum[CREDIT_W] ? '1 : sum[CREDIT_W-1:0];
      end
   end

   assign vco_o = vco_q;

   assert_vco_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwrdn_i) |-> !vco_q);
endmodule

// File: rtl/pllc_divider.sv
module pllc_divider #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] ratio_i,
   output logic             pulse_o
);
   logic [DIV_W-1:0] cnt_q;

   assign pulse_o = tick_i && (cnt_q >= ratio_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= pulse_o ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/pllc_clk_mux.sv
module pllc_clk_mux (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic ref_i,
   input  logic pll_i,
   output logic sel_o,
   output logic clk_en_o
);
   logic sel_q;
   logic quiet;

   assign quiet = !ref_i && !pll_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_q <= 1'b0;
      else if (quiet) sel_q <= en_i;
   end

   assign sel_o    = sel_q;
   assign clk_en_o = sel_q ? pll_i : ref_i;

   assert_switch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != $past(sel_q)) |-> $past(!ref_i && !pll_i));
endmodule

// File: rtl/pllc_ddr_clkgen.sv
module pllc_ddr_clkgen
   import pllc_pkg::*;
#(
   parameter int DW         = 8,
   parameter int MULT_W     = 6,
   parameter int DIV_W      = 4,
   parameter int LOCK_TICKS = 8,
   parameter int MULT_RST   = 4,
   parameter int POST_RST   = 1,
   parameter int BYP_RST    = 0,
   parameter bit EXT_REF_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              ext_tick,
   input  logic              src_ext,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              mem_clk_en,
   output logic              byp_clk_en,
   output logic              pll_locked,
   output logic              pll_selected
);
   localparam int CREDIT_W = MULT_W + 2;

   if (DW < 3 || DW < MULT_W || DW < DIV_W) begin : g_bad_dw
      $error("DW too narrow for register fields");
   end
   if (LOCK_TICKS < 2) begin : g_bad_lock
      $error("LOCK_TICKS must be at least 2");
   end
   if (MULT_RST >= (1 << MULT_W) || POST_RST >= (1 << DIV_W) || BYP_RST >= (1 << DIV_W)) begin : g_bad_rst
      $error("reset value does not fit its field");
   end

   logic ref_t;
   logic pwrdn, en, mult_wr, locked, vco_pulse, post_pulse;
   logic [MULT_W-1:0] mult_eff;
   logic [DIV_W-1:0]  post_ratio, byp_ratio;

   if (EXT_REF_EN) begin : g_ref_mux
      assign ref_t = src_ext ? ext_tick : osc_tick;
   end else begin : g_ref_osc
      logic unused_ext;
      assign unused_ext = ext_tick ^ src_ext;
      assign ref_t = osc_tick;
   end

   pllc_regs #(
      .DW(DW), .MULT_W(MULT_W), .DIV_W(DIV_W),
      .MULT_RST(MULT_RST), .POST_RST(POST_RST), .BYP_RST(BYP_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .locked_i(locked), .rdata_o(reg_rdata),
      .pwrdn_o(pwrdn), .en_o(en), .mult_wr_o(mult_wr),
      .mult_eff_o(mult_eff), .post_o(post_ratio), .byp_o(byp_ratio)
   );

   pllc_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
      .clk(clk), .rst_n(rst_n), .pwrdn_i(pwrdn), .restart_i(mult_wr),
      .ref_i(ref_t), .locked_o(locked)
   );

   pllc_vco_model #(.MULT_W(MULT_W), .CREDIT_W(CREDIT_W)) u_vco (
      .clk(clk), .rst_n(rst_n), .pwrdn_i(pwrdn), .ref_i(ref_t),
      .mult_i(mult_eff), .vco_o(vco_pulse)
   );

   pllc_divider #(.DIV_W(DIV_W)) u_post_div (
      .clk(clk), .rst_n(rst_n), .clr_i(pwrdn), .tick_i(vco_pulse),
      .ratio_i(post_ratio), .pulse_o(post_pulse)
   );

   pllc_divider #(.DIV_W(DIV_W)) u_byp_div (
      .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(ref_t),
      .ratio_i(byp_ratio), .pulse_o(byp_clk_en)
   );

   pllc_clk_mux u_mux (
      .clk(clk), .rst_n(rst_n), .en_i(en), .ref_i(ref_t),
      .pll_i(post_pulse), .sel_o(pll_selected), .clk_en_o(mem_clk_en)
   );

   assign pll_locked = locked;

   assert_pll_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_selected && mem_clk_en) |-> vco_pulse);
   assert_byp_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byp_clk_en |-> ref_t);
   assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_selected && mem_clk_en) |-> !vco_pulse || ref_t);
endmodule

// File: tb/tb_pllc_ddr_clkgen.sv
module tb_pllc_ddr_clkgen;
   localparam int DW = 8, MULT_W = 6, DIV_W = 4, LOCK_TICKS = 8;
   localparam int CMAX = (1 << (MULT_W + 2)) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic osc_tick = 1'b0, ext_tick = 1'b0, src_ext = 1'b0;
   logic reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic mem_clk_en, byp_clk_en, pll_locked, pll_selected;

   int checks = 0, fails = 0, cycles = 0;

   pllc_ddr_clkgen #(.DW(DW), .MULT_W(MULT_W), .DIV_W(DIV_W), .LOCK_TICKS(LOCK_TICKS)) dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_tick(ext_tick),
      .src_ext(src_ext), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_clk_en(mem_clk_en),
      .byp_clk_en(byp_clk_en), .pll_locked(pll_locked), .pll_selected(pll_selected)
   );

   always #4 clk = ~clk;

   // reference model state
   int m_pwrdn, m_en, m_lock, m_mult, m_post, m_byp;
   int m_credit, m_vco, m_pcnt, m_bcnt, m_lcnt, m_sel;

   function automatic int f_ref();
      return src_ext ? int'(ext_tick) : int'(osc_tick);
   endfunction
   function automatic int f_post_p();
      return (m_vco != 0 && m_pcnt >= m_post) ? 1 : 0;
   endfunction
   function automatic int f_mem();
      return m_sel != 0 ? f_post_p() : f_ref();
   endfunction
   function automatic int f_byp();
      return (f_ref() != 0 && m_bcnt >= m_byp) ? 1 : 0;
   endfunction
   function automatic int f_rdata();
      case (reg_addr)
         2'd0: return m_pwrdn | (m_en << 1) | (m_lock << 2);
         2'd1: return m_mult;
         2'd2: return m_post;
         default: return m_byp;
      endcase
   endfunction

   task automatic model_reset();
      m_pwrdn = 1; m_en = 0; m_lock = 0; m_mult = 4; m_post = 1; m_byp = 0;
      m_credit = 0; m_vco = 0; m_pcnt = 0; m_bcnt = 0; m_lcnt = 0; m_sel = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int r, pp, bp, wc, wm, meff;
         int n_pwrdn, n_en, n_lock, n_mult, n_post, n_byp;
         int n_credit, n_vco, n_pcnt, n_bcnt, n_lcnt, n_sel;
         r = f_ref(); pp = f_post_p(); bp = f_byp();
         wc = (reg_we && reg_addr == 2'd0) ? 1 : 0;
         wm = (reg_we && reg_addr == 2'd1) ? 1 : 0;
         meff = (m_mult == 0) ? 1 : m_mult;
         n_pwrdn = wc ? int'(reg_wdata[0]) : m_pwrdn;
         n_mult  = wm ? int'(reg_wdata[MULT_W-1:0]) : m_mult;
         n_post  = (reg_we && reg_addr == 2'd2) ? int'(reg_wdata[DIV_W-1:0]) : m_post;
         n_byp   = (reg_we && reg_addr == 2'd3) ? int'(reg_wdata[DIV_W-1:0]) : m_byp;
         n_en    = m_lock & (wc ? int'(reg_wdata[1]) : m_en);
         n_lock = m_lock; n_lcnt = m_lcnt;
         if (m_pwrdn != 0 || wm != 0) begin n_lock = 0; n_lcnt = 0; end
         else if (r != 0 && m_lock == 0) begin
            if (m_lcnt == LOCK_TICKS - 1) n_lock = 1; else n_lcnt = m_lcnt + 1;
         end
         if (m_pwrdn != 0) begin n_credit = 0; n_vco = 0; end
         else begin
            n_vco = (m_credit != 0) ? 1 : 0;
            n_credit = m_credit + (r != 0 ? meff : 0) - n_vco;
            if (n_credit > CMAX) n_credit = CMAX;
         end
         n_pcnt = m_pcnt;
         if (m_pwrdn != 0) n_pcnt = 0;
         else if (m_vco != 0) n_pcnt = pp != 0 ? 0 : m_pcnt + 1;
         n_bcnt = m_bcnt;
         if (r != 0) n_bcnt = bp != 0 ? 0 : m_bcnt + 1;
         n_sel = (r == 0 && pp == 0) ? m_en : m_sel;
         m_pwrdn = n_pwrdn; m_en = n_en; m_lock = n_lock; m_mult = n_mult;
         m_post = n_post; m_byp = n_byp; m_credit = n_credit; m_vco = n_vco;
         m_pcnt = n_pcnt; m_bcnt = n_bcnt; m_lcnt = n_lcnt; m_sel = n_sel;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // per-cycle comparison away from the clock edges
   always begin
      @(negedge clk); #2;
      cycles++;
      if (rst_n) begin
         check(int'(mem_clk_en) == f_mem(), "R2 R3 R6 R7 mem_clk_en", int'(mem_clk_en), f_mem());
         check(int'(byp_clk_en) == f_byp(), "R8 byp_clk_en", int'(byp_clk_en), f_byp());
         check(int'(pll_locked) == m_lock, "R4 pll_locked", int'(pll_locked), m_lock);
         check(int'(pll_selected) == m_sel, "R9 pll_selected", int'(pll_selected), m_sel);
         check(int'(reg_rdata) == f_rdata(), "R10 reg_rdata", int'(reg_rdata), f_rdata());
      end
   end

   // reference tick generators: osc every 5 cycles, ext every 7
   always begin
      int oc = 0, ec = 0;
      forever begin
         @(negedge clk);
         oc = (oc == 4) ? 0 : oc + 1;
         ec = (ec == 6) ? 0 : ec + 1;
         osc_tick = (oc == 0);
         ext_tick = (ec == 0);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = 2'(a);
      #2 d = int'(reg_rdata);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_mem(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #2;
         if (mem_clk_en) c++;
      end
   endtask

   task automatic count_byp(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #2;
         if (byp_clk_en) c++;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      finish_run();
   end

   initial begin
      int v, c;
      idle(5);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, v); check(v == 1, "R1 ctrl reset", v, 1);
      rd(1, v); check(v == 4, "R1 mult reset", v, 4);
      rd(2, v); check(v == 1, "R1 post reset", v, 1);
      rd(3, v); check(v == 0, "R1 byp reset", v, 0);
      check(pll_selected == 1'b0, "R1 bypass at reset", int'(pll_selected), 0);
      // R2 bypass follows oscillator, R8 bypass divider by 3
      wr(3, 2);
      count_mem(210, c); check(c == 42, "R2 bypass osc rate", c, 42);
      count_byp(210, c); check(c == 14, "R8 bypass divide by 3", c, 14);
      // R5 enable before lock is ignored
      wr(0, 3);
      rd(0, v); check(v == 1, "R5 enable ignored unlocked", v, 1);
      // R4 power up and lock
      wr(0, 0);
      idle(4);
      rd(0, v); check((v & 4) == 0, "R4 not yet locked", v & 4, 0);
      idle(LOCK_TICKS * 5 + 5);
      rd(0, v); check(v == 4, "R4 locked after count", v, 4);
      // R6 R7: mult 4, post 1 -> 2 mem pulses per ref tick
      wr(0, 2);
      idle(20);
      check(pll_selected == 1'b1, "R9 switched to pll", int'(pll_selected), 1);
      count_mem(200, c); check(c >= 78 && c <= 82, "R7 pll x4 div2 rate", c, 80);
      // R4 R5: multiplier write drops lock and enable
      wr(1, 0);
      idle(3);
      rd(0, v); check(v == 0, "R5 enable cleared on lock loss", v, 0);
      idle(20);
      check(pll_selected == 1'b0, "R5 back in bypass", int'(pll_selected), 0);
      idle(LOCK_TICKS * 5 + 5);
      wr(2, 2); wr(0, 2);
      idle(30);
      // R6 mult 0 acts as x1, post 2 -> ref/3
      count_mem(210, c); check(c >= 13 && c <= 15, "R6 mult zero as one", c, 14);
      // R3 external reference in PLL mode: mult 3, post 0
      src_ext = 1'b1;
      wr(1, 3);
      idle(LOCK_TICKS * 7 + 10);
      wr(2, 0); wr(0, 2);
      idle(30);
      count_mem(210, c); check(c >= 88 && c <= 92, "R3 ext ref pll x3", c, 90);
      // power down while on PLL: falls back to external bypass
      wr(0, 1);
      idle(20);
      check(pll_locked == 1'b0, "R4 power-down clears lock", int'(pll_locked), 0);
      count_mem(210, c); check(c == 30, "R3 ext bypass rate", c, 30);
      wr(3, 0);
      idle(7);
      count_byp(210, c); check(c == 30, "R8 bypass divide by 1", c, 30);
      idle(10);
      finish_run();
   end
endmodule